// File: doc/BRIEF.md
# Soft-Mute Attenuation Ramp Controller

This block produces a playback attenuation in whole decibels that follows a clock-error indication. While the error is present, the attenuation climbs one dB at a time until it reaches a full-mute level. When the error goes away, it descends one dB at a time back to 0 dB. Because the gain never jumps, both muting and unmuting are free of audible pops. A separate gain stage, which is outside this block, applies the value to the audio samples.

The time spent on each dB step is counted in pulses of a 1 µs tick input. A 2-bit rate code selects how many ticks make up one step. The same step time applies in both directions. If the error changes state partway through a ramp, the ramp turns around from the present value and starts a fresh step timing. Two flags accompany the value: one shows that full mute has been reached, and the other shows that the attenuation is still moving toward its target.

Top module: `softmute_ramp`

## Requirements
- R1: After reset the attenuation is 0 dB, the muted flag is low and, with no error applied, the busy flag is low.
- R2: The number of ticks per 1 dB step is 15 << rate_i. Rate code 00 gives 15 ticks, 01 gives 30, 10 gives 60 and 11 gives 120. The first step after an error edge happens on the dwell-th tick counted from the cycle after that edge.
- R3: While err_i is high, the attenuation rises to 110 dB and stays there. muted_o is high exactly when the attenuation equals 110.
- R4: While err_i is low, the attenuation falls to 0 dB at the same dwell per step and stays at 0.
- R5: The attenuation changes by at most 1 dB per clock, and only on a clock edge where tick_i is high.
- R6: In the clock where err_i differs from its value on the previous clock, the attenuation does not change and the dwell count restarts. A reversal therefore continues from the current value after a full dwell.
- R7: busy_o is high exactly when the attenuation differs from its target, which is 110 with err_i high and 0 with err_i low. While busy_o is low the attenuation holds.
- R8: If the rate code is lowered mid-step to a dwell already exceeded by the tick count, the step is taken on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | 1 | Clock-error indication; high requests mute |
| rate_i | input | 2 | Dwell code; the step time is 15 << rate_i ticks |
| tick_i | input | 1 | 1 µs timing pulse, one clock wide |
| atten_o | output | 7 | Present attenuation in dB (0 to 110) |
| muted_o | output | 1 | High when attenuation is at full mute |
| busy_o | output | 1 | High while attenuation is moving toward its target |

## Verification
The hardest situation to reach is an error reversal that lands partway through a dwell while the attenuation is between its limits. A related case is a rate code lowered after the tick count has already passed the new dwell. Directed sequences set up both cases: they ramp to a known intermediate value, wait a known number of ticks, and then toggle err_i or drop the rate code. Long random phases also toggle the error and the rate code with low probability while ticks arrive irregularly, so that reversals fall at many different count positions. A cycle-level model built from the requirements checks the attenuation and both flags on every clock.

// File: rtl/softmute_ramp.sv
module softmute_ramp #(
  parameter int MAX_DB     = 110,
  parameter int BASE_DWELL = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_i,
  input  logic [1:0] rate_i,
  input  logic       tick_i,
  output logic [6:0] atten_o,
  output logic       muted_o,
  output logic       busy_o
);
  localparam int AW = $clog2(MAX_DB + 1);
  localparam int CW = $clog2(BASE_DWELL * 8 + 1);

  logic [AW-1:0] atten_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;

  logic [CW-1:0] dwell;
  logic at_top, at_zero, flip, last;

  assign dwell   = CW'(BASE_DWELL) << rate_i;
  assign at_top  = atten_q == AW'(MAX_DB);
  assign at_zero = atten_q == '0;
  assign flip    = err_i != err_q;
  assign last    = cnt_q >= dwell - CW'(1);

  assign busy_o  = err_i ? !at_top : !at_zero;
  assign muted_o = at_top;
  assign atten_o = 7'(atten_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      atten_q <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_i;
      if (flip || !busy_o) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (last) begin
          cnt_q   <= '0;
          atten_q <= err_i ? atten_q + AW'(1) : atten_q - AW'(1);
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    int'(atten_o) <= MAX_DB);

  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(atten_o) == int'($past(atten_o))) ||
    (int'(atten_o) == int'($past(atten_o)) + 1) ||
    (int'(atten_o) + 1 == int'($past(atten_o))));

  a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (atten_o != $past(atten_o)) |-> $past(tick_i));

  a_r6_flip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i != $past(err_i)) |=> $stable(atten_o));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(atten_o));

  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_i && atten_o == 7'd0) |=> atten_o == 7'd0);
endmodule

// File: tb/tb_softmute_ramp.sv
`timescale 1ns/1ps
module tb_softmute_ramp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_i = 1'b0;
  logic [1:0] rate_i = 2'b00;
  logic tick_i = 1'b0;
  logic [6:0] atten_o;
  logic muted_o, busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_att = 0;
  int m_cnt = 0;
  bit m_errq = 1'b0;

  softmute_ramp dut (.clk(clk), .rst_n(rst_n), .err_i(err_i), .rate_i(rate_i),
                     .tick_i(tick_i), .atten_o(atten_o), .muted_o(muted_o), .busy_o(busy_o));

  always #10 clk = ~clk;

  function automatic int dwell_of(input logic [1:0] r);
    return 15 << r;
  endfunction

  function automatic bit exp_busy(input int att, input bit e);
    return e ? (att < 110) : (att > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_att = 0; m_cnt = 0; m_errq = 1'b0;
    end else begin
      if (err_i != m_errq || !exp_busy(m_att, err_i)) m_cnt = 0;
      else if (tick_i) begin
        if (m_cnt >= dwell_of(rate_i) - 1) begin
          m_cnt = 0;
          m_att = err_i ? m_att + 1 : m_att - 1;
        end else m_cnt = m_cnt + 1;
      end
      m_errq = err_i;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk(int'(atten_o) == m_att, "R5 attenuation vs model", int'(atten_o), m_att);
    chk(muted_o == (m_att == 110), "R3 muted flag", int'(muted_o), int'(m_att == 110));
    chk(busy_o == exp_busy(m_att, err_i), "R7 busy flag", int'(busy_o), int'(exp_busy(m_att, err_i)));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      model_cmp();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(atten_o == 7'd0, "R1 reset attenuation", int'(atten_o), 0);
    chk(!muted_o, "R1 reset muted", int'(muted_o), 0);
    chk(!busy_o, "R1 reset busy", int'(busy_o), 0);

    // R2: first step after error edge takes 1 + dwell edges, for every rate
    tick_i = 1'b1;
    for (int r = 0; r < 4; r++) begin
      rate_i = 2'(r);
      err_i = 1'b1;
      run(15 << r);
      chk(atten_o == 7'd0, "R2 no step before dwell", int'(atten_o), 0);
      run(1);
      chk(atten_o == 7'd1, "R2 step at dwell", int'(atten_o), 1);
      err_i = 1'b0;
      run(1 + (15 << r));
      chk(atten_o == 7'd0, "R4 back to zero", int'(atten_o), 0);
    end

    // R3: full mute at rate 00
    rate_i = 2'b00;
    err_i = 1'b1;
    run(1 + 110 * 15 - 1);
    chk(atten_o == 7'd109, "R3 one short of mute", int'(atten_o), 109);
    chk(!muted_o, "R3 not yet muted", int'(muted_o), 0);
    run(1);
    chk(atten_o == 7'd110, "R3 full mute", int'(atten_o), 110);
    chk(muted_o && !busy_o, "R3 muted and idle", int'({muted_o, busy_o}), 2);
    run(200);
    chk(atten_o == 7'd110, "R3 saturates", int'(atten_o), 110);

    // R4: unmute at same dwell
    err_i = 1'b0;
    run(1 + 110 * 15);
    chk(atten_o == 7'd0 && !busy_o, "R4 unmuted", int'(atten_o), 0);
    run(100);
    chk(atten_o == 7'd0, "R4 stays at zero", int'(atten_o), 0);

    // R6: reversal mid-dwell at 5 dB
    err_i = 1'b1;
    run(1 + 5 * 15 + 7);
    chk(atten_o == 7'd5, "R6 setup", int'(atten_o), 5);
    err_i = 1'b0;
    run(15);
    chk(atten_o == 7'd5, "R6 full dwell after reversal", int'(atten_o), 5);
    run(1);
    chk(atten_o == 7'd4, "R6 reversed step", int'(atten_o), 4);

    // R5: no ticks, no movement
    tick_i = 1'b0;
    run(300);
    chk(atten_o == 7'd4, "R5 no tick no change", int'(atten_o), 4);
    tick_i = 1'b1;
    err_i = 1'b0;
    run(1 + 4 * 15);
    chk(atten_o == 7'd0, "R4 drained", int'(atten_o), 0);

    // R8: rate lowered after count passed new dwell
    rate_i = 2'b11;
    err_i = 1'b1;
    run(1 + 50);
    chk(atten_o == 7'd0, "R8 setup", int'(atten_o), 0);
    rate_i = 2'b00;
    run(1);
    chk(atten_o == 7'd1, "R8 immediate step", int'(atten_o), 1);
    err_i = 1'b0;
    run(1 + 15);

    // random phase
    for (int i = 0; i < 120000; i++) begin
      tick_i = ($urandom % 3) != 0;
      if ($urandom % 2500 == 0) err_i = ~err_i;
      if ($urandom % 4000 == 0) rate_i = 2'($urandom % 4);
      run(1);
    end
    finish_run();
  end
endmodule